// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Controller

This block is the tag and state engine of a single-level set-associative cache. It accepts one request at a time: a read, a write, or an invalidate of one address. It decides hit or miss and, on a miss, picks a victim way. It also tracks dirty lines so that main memory is written only when a modified line leaves the cache. The block holds no data. A fill from the next level is modelled as a fixed wait of `FILL_LAT` cycles, after which the new line is installed and the response is issued.

The replacement policy is an input and may change between requests. Three rules share one per-set ordering:
- oldest-filled-out (FIFO)
- least-recently-used (LRU)
- most-recently-used (MRU)

Every read or write response reports hit, eviction and writeback, together with the block address of the written-back line. Four running counters accumulate hits, misses, evictions and writebacks.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The request address is split from the LSB upward into a byte offset of log2(BLOCK_BYTES) bits, a set index of log2(SETS) bits and a tag in the remaining bits, where SETS = CACHE_BYTES/(BLOCK_BYTES*WAYS). Two addresses that differ only in the offset hit the same line.
- R2: `req_op_i` is decoded as 0 read, 1 write, 2 invalidate, and 3 read. A request is taken when `req_valid_i` and `req_ready_o` are both high. For a hit or an invalidate, `resp_valid_o` pulses on the next cycle. For a read or write miss, the pulse comes FILL_LAT+1 cycles after acceptance, and `req_ready_o` stays low until the line is installed.
- R3: A miss fills an invalid way when the set has one, and reports no eviction. A valid line is evicted only when all WAYS lines of the set are valid.
- R4: With `policy_i`=0 (FIFO), the victim is the line filled earliest in the set, and hits leave the order unchanged.
- R5: With `policy_i`=1 (LRU), or the value 3, which behaves the same, every hit and every fill makes that line the most recent. The victim is the least recently used line.
- R6: With `policy_i`=2 (MRU), every hit and every fill makes that line the most recent, and the victim is the most recently used line.
- R7: A write hit sets the line's dirty bit. A write miss allocates the line and then marks it dirty. Neither case reports a writeback.
- R8: `resp_wb_o` is raised only when a dirty line is evicted or invalidated. `wb_addr_o` then carries that line's block address: its tag and set index, with a zero offset.
- R9: An invalidate clears the matching line and reports its presence on `resp_hit_o`. It never reports an eviction, and a later access to that address misses.
- R10: The counters track responses. A read or write hit adds one to the hit count, and a read or write miss adds one to the miss count. Each evicted valid line adds one to the eviction count, and each writeback adds one to the writeback count.
- R11: After reset, all lines are invalid and clean, all counters read zero, `req_ready_o` is high and `resp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Request kind: read, write, invalidate |
| req_addr_i | input | ADDR_W | Byte address of the request |
| policy_i | input | 2 | Replacement rule used for this request |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_hit_o | output | 1 | Line was present |
| resp_evict_o | output | 1 | A valid line was replaced |
| resp_wb_o | output | 1 | A dirty line left the cache |
| wb_addr_o | output | ADDR_W | Block address of the written-back line |
| hit_cnt_o | output | CNT_W | Hit count |
| miss_cnt_o | output | CNT_W | Miss count |
| evict_cnt_o | output | CNT_W | Eviction count |
| wb_cnt_o | output | CNT_W | Writeback count |

## Verification
The assertions assume that `req_op_i`, `req_addr_i` and `policy_i` are stable and defined while `req_valid_i` is high. They also assume that requests arrive only through the ready handshake, so no lookup ever overlaps a pending fill. The stimulus raises `req_valid_i` for exactly one cycle while the controller is idle, and waits for each response before the next request. This holds for directed runs and for a long pseudo-random mix that uses six tags per set across four sets, so that evictions, dirty victims, invalidates and policy switches occur constantly.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  typedef enum logic [1:0] {
    POL_FIFO    = 2'd0,
    POL_LRU     = 2'd1,
    POL_MRU     = 2'd2,
    POL_LRU_ALT = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_INVAL    = 2'd2,
    OP_READ_ALT = 2'd3
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } state_e;
endpackage

// File: rtl/wbc_lookup.sv
`timescale 1ns/1ps
module wbc_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int WAY_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WAYS-1:0]        valid_i,
  input  logic [WAYS*TAG_W-1:0]  tags_i,
  input  logic [WAYS*WAY_W-1:0]  ages_i,
  input  logic [TAG_W-1:0]       tag_i,
  input  logic                   mru_sel_i,
  output logic                   hit_o,
  output logic [WAY_W-1:0]       hit_way_o,
  output logic [WAY_W-1:0]       vic_way_o,
  output logic                   vic_valid_o
);
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  age_eq;
  logic [WAY_W-1:0] tgt_age;

  assign tgt_age = mru_sel_i ? '0 : '1;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign match[g]  = valid_i[g] && (tags_i[g*TAG_W +: TAG_W] == tag_i);
    assign age_eq[g] = valid_i[g] && (ages_i[g*WAY_W +: WAY_W] == tgt_age);
  end

  assign hit_o       = |match;
  assign vic_valid_o = &valid_i;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way_o = WAY_W'(w);
  end

  // lowest free way first; else the way holding the policy's target age
  always_comb begin
    vic_way_o = '0;
    if (!vic_valid_o) begin
      for (int w = WAYS-1; w >= 0; w--)
        if (!valid_i[w]) vic_way_o = WAY_W'(w);
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (age_eq[w]) vic_way_o = WAY_W'(w);
    end
  end

  a_r1_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // full set must hold a permutation of ages, so exactly one target
  a_r3_unique_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) |-> ($countones(age_eq) == 1));
endmodule

// File: rtl/wbc_age_upd.sv
`timescale 1ns/1ps
module wbc_age_upd #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]        valid_i,
  input  logic [WAYS*WAY_W-1:0]  ages_i,
  input  logic [WAY_W-1:0]       way_i,
  input  logic                   touch_i,
  input  logic                   inval_i,
  output logic [WAYS*WAY_W-1:0]  ages_o
);
  logic [WAY_W-1:0] ref_age;

  // age 0 = newest; a free way acts as older than every valid one
  assign ref_age = valid_i[way_i] ? ages_i[way_i*WAY_W +: WAY_W] : '1;

  always_comb begin
    for (int v = 0; v < WAYS; v++) begin
      logic [WAY_W-1:0] a;
      logic [WAY_W-1:0] n;
      a = ages_i[v*WAY_W +: WAY_W];
      n = a;
      if (touch_i) begin
        if (WAY_W'(v) == way_i)            n = '0;
        else if (valid_i[v] && a < ref_age) n = a + 1'b1;
      end else if (inval_i) begin
        if (WAY_W'(v) != way_i && valid_i[v] && a > ref_age) n = a - 1'b1;
      end
      ages_o[v*WAY_W +: WAY_W] = n;
    end
  end
endmodule

// File: rtl/wbc_counters.sv
`timescale 1ns/1ps
module wbc_counters #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       inc_i,
  output logic [N*CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[g]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
`timescale 1ns/1ps
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CACHE_BYTES = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int FILL_LAT    = 3,
  parameter int CNT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        policy_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_evict_o,
  output logic              resp_wb_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  evict_cnt_o,
  output logic [CNT_W-1:0]  wb_cnt_o
);
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int FC_W  = $clog2(FILL_LAT + 1);

  state_e                  state_q;
  logic [FC_W-1:0]         fill_cnt_q;
  logic [WAYS-1:0]         valid_q [SETS];
  logic [WAYS-1:0]         dirty_q [SETS];
  logic [WAYS*TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS*WAY_W-1:0]   age_q   [SETS];

  logic [IDX_W-1:0]  p_idx_q;
  logic [TAG_W-1:0]  p_tag_q;
  logic [WAY_W-1:0]  p_way_q;
  logic              p_write_q, p_evict_q, p_wb_q;
  logic [ADDR_W-1:0] p_wb_addr_q;

  logic              resp_valid_q, resp_hit_q, resp_evict_q, resp_wb_q;
  logic [ADDR_W-1:0] wb_addr_q;

  op_e              op;
  policy_e          pol;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             is_inv, is_wr, is_fifo, is_mru;
  logic             acc, fill_done;
  logic             hit, vic_valid;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [TAG_W-1:0] vic_tag;
  logic             hit_dirty, vic_dirty;

  assign op      = op_e'(req_op_i);
  assign pol     = policy_e'(policy_i);
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign is_inv  = (op == OP_INVAL);
  assign is_wr   = (op == OP_WRITE);
  assign is_fifo = (pol == POL_FIFO);
  assign is_mru  = (pol == POL_MRU);

  assign req_ready_o = (state_q == ST_IDLE);
  assign acc         = req_valid_i && req_ready_o;
  assign fill_done   = (state_q == ST_FILL) && (fill_cnt_q == '0);

  wbc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_q[req_idx]),
    .tags_i     (tag_q[req_idx]),
    .ages_i     (age_q[req_idx]),
    .tag_i      (req_tag),
    .mru_sel_i  (is_mru),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .vic_way_o  (vic_way),
    .vic_valid_o(vic_valid)
  );

  assign vic_tag   = tag_q[req_idx][vic_way*TAG_W +: TAG_W];
  assign hit_dirty = dirty_q[req_idx][hit_way];
  assign vic_dirty = dirty_q[req_idx][vic_way];

  // replacement order update
  logic [IDX_W-1:0]       upd_idx;
  logic [WAY_W-1:0]       upd_way;
  logic                   upd_touch, upd_inval;
  logic [WAYS*WAY_W-1:0]  upd_ages;

  assign upd_idx   = fill_done ? p_idx_q : req_idx;
  assign upd_way   = fill_done ? p_way_q : hit_way;
  assign upd_touch = fill_done || (acc && hit && !is_inv && !is_fifo);
  assign upd_inval = acc && hit && is_inv;

  wbc_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .valid_i(valid_q[upd_idx]),
    .ages_i (age_q[upd_idx]),
    .way_i  (upd_way),
    .touch_i(upd_touch),
    .inval_i(upd_inval),
    .ages_o (upd_ages)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (upd_touch || upd_inval) begin
      age_q[upd_idx] <= upd_ages;
    end
  end

  // request / fill sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fill_cnt_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tag_q[s]   <= '0;
      end
      p_idx_q      <= '0;
      p_tag_q      <= '0;
      p_way_q      <= '0;
      p_write_q    <= 1'b0;
      p_evict_q    <= 1'b0;
      p_wb_q       <= 1'b0;
      p_wb_addr_q  <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_evict_q <= 1'b0;
      resp_wb_q    <= 1'b0;
      wb_addr_q    <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      if (acc) begin
        if (is_inv) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= hit;
          resp_evict_q <= 1'b0;
          resp_wb_q    <= hit && hit_dirty;
          wb_addr_q    <= {req_tag, req_idx, {OFF_W{1'b0}}};
          if (hit) begin
            valid_q[req_idx][hit_way] <= 1'b0;
            dirty_q[req_idx][hit_way] <= 1'b0;
          end
        end else if (hit) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b1;
          resp_evict_q <= 1'b0;
          resp_wb_q    <= 1'b0;
          if (is_wr) dirty_q[req_idx][hit_way] <= 1'b1;
        end else begin
          state_q     <= ST_FILL;
          fill_cnt_q  <= FC_W'(FILL_LAT - 1);
          p_idx_q     <= req_idx;
          p_tag_q     <= req_tag;
          p_way_q     <= vic_way;
          p_write_q   <= is_wr;
          p_evict_q   <= vic_valid;
          p_wb_q      <= vic_valid && vic_dirty;
          p_wb_addr_q <= {vic_tag, req_idx, {OFF_W{1'b0}}};
        end
      end else if (state_q == ST_FILL) begin
        if (fill_done) begin
          state_q                   <= ST_IDLE;
          valid_q[p_idx_q][p_way_q] <= 1'b1;
          dirty_q[p_idx_q][p_way_q] <= p_write_q;
          tag_q[p_idx_q][p_way_q*TAG_W +: TAG_W] <= p_tag_q;
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b0;
          resp_evict_q <= p_evict_q;
          resp_wb_q    <= p_wb_q;
          wb_addr_q    <= p_wb_addr_q;
        end else begin
          fill_cnt_q <= fill_cnt_q - 1'b1;
        end
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_evict_o = resp_evict_q;
  assign resp_wb_o    = resp_wb_q;
  assign wb_addr_o    = wb_addr_q;

  logic [3:0]         cnt_inc;
  logic [4*CNT_W-1:0] cnt_all;

  assign cnt_inc[0] = acc && hit && !is_inv;
  assign cnt_inc[1] = fill_done;
  assign cnt_inc[2] = fill_done && p_evict_q;
  assign cnt_inc[3] = (fill_done && p_wb_q) || (acc && is_inv && hit && hit_dirty);

  wbc_counters #(.N(4), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (cnt_inc),
    .cnt_o (cnt_all)
  );

  assign hit_cnt_o   = cnt_all[0*CNT_W +: CNT_W];
  assign miss_cnt_o  = cnt_all[1*CNT_W +: CNT_W];
  assign evict_cnt_o = cnt_all[2*CNT_W +: CNT_W];
  assign wb_cnt_o    = cnt_all[3*CNT_W +: CNT_W];

  a_r2_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && hit && !is_inv) |=> (resp_valid_o && resp_hit_o));

  a_r2_miss_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !hit && !is_inv) |=> (!req_ready_o && !resp_valid_o));

  a_r9_evict_only_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_evict_o) |-> !resp_hit_o);

  a_r10_hit_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (resp_valid_o && resp_hit_o));

  a_r10_wb_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cnt_o != $past(wb_cnt_o)) |-> (resp_valid_o && resp_wb_o));
endmodule

// File: tb/wb_cache_ctrl_bench.sv
`timescale 1ns/1ps
module wb_cache_ctrl_bench;
  localparam int ADDR_W = 12, CACHE_BYTES = 256, BLOCK_BYTES = 16, WAYS = 4;
  localparam int FILL_LAT = 3, CNT_W = 16;
  localparam int SETS = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = 4, IDX_W = 2, TAG_W = ADDR_W - OFF_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0, policy = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, resp_evict, resp_wb;
  logic [ADDR_W-1:0] wb_addr;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, evict_cnt, wb_cnt;

  always #2.5 clk = ~clk;

  wb_cache_ctrl #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
                  .WAYS(WAYS), .FILL_LAT(FILL_LAT), .CNT_W(CNT_W)) u_wb_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .policy_i(policy), .req_ready_o(req_ready),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_evict_o(resp_evict),
    .resp_wb_o(resp_wb), .wb_addr_o(wb_addr), .hit_cnt_o(hit_cnt),
    .miss_cnt_o(miss_cnt), .evict_cnt_o(evict_cnt), .wb_cnt_o(wb_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int e_hit = 0, e_miss = 0, e_evict = 0, e_wb = 0;
  bit done = 1'b0;

  // model: per set, list position 0 = newest
  int m_len [SETS];
  int m_tag [SETS][WAYS];
  bit m_dirty [SETS][WAYS];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_remove(input int ix, input int p);
    for (int q = p; q < m_len[ix]-1; q++) begin
      m_tag[ix][q]   = m_tag[ix][q+1];
      m_dirty[ix][q] = m_dirty[ix][q+1];
    end
    m_len[ix]--;
  endtask

  task automatic m_push(input int ix, input int t, input bit d);
    for (int q = m_len[ix]; q > 0; q--) begin
      m_tag[ix][q]   = m_tag[ix][q-1];
      m_dirty[ix][q] = m_dirty[ix][q-1];
    end
    m_tag[ix][0] = t; m_dirty[ix][0] = d;
    m_len[ix]++;
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int t, input int ix, input int off);
    return {TAG_W'(t), IDX_W'(ix), OFF_W'(off)};
  endfunction

  task automatic access(input logic [1:0] op, input int t, input int ix, input int off,
                        input logic [1:0] pol, input string req);
    int pos = -1;
    bit x_hit, x_ev = 0, x_wb = 0;
    logic [ADDR_W-1:0] x_addr = '0;
    int x_lat, n;
    bit wr = (op == 2'd1);
    for (int p = 0; p < m_len[ix]; p++) if (m_tag[ix][p] == t) pos = p;
    x_hit = (pos >= 0);
    if (op == 2'd2) begin
      if (x_hit) begin
        x_wb = m_dirty[ix][pos]; x_addr = mk_addr(t, ix, 0);
        m_remove(ix, pos);
      end
      x_lat = 1;
    end else if (x_hit) begin
      bit d = m_dirty[ix][pos] | wr;
      if (pol != 2'd0) begin m_remove(ix, pos); m_push(ix, t, d); end
      else m_dirty[ix][pos] = d;
      e_hit++; x_lat = 1;
    end else begin
      if (m_len[ix] == WAYS) begin
        int v = (pol == 2'd2) ? 0 : WAYS-1;
        x_ev = 1; x_wb = m_dirty[ix][v];
        x_addr = mk_addr(m_tag[ix][v], ix, 0);
        m_remove(ix, v);
      end
      m_push(ix, t, wr);
      e_miss++; x_lat = FILL_LAT + 1;
    end
    if (x_ev) e_evict++;
    if (x_wb) e_wb++;

    @(negedge clk);
    req_op = op; req_addr = mk_addr(t, ix, off); policy = pol; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (x_lat > 1) chk("R2", "ready during fill", req_ready, 0);
    n = 1;
    while (!resp_valid && n < 40) begin @(negedge clk); n++; end
    chk("R2", "latency", n, x_lat);
    chk(req, "hit", resp_hit, x_hit);
    chk(x_ev ? req : "R3", "evict", resp_evict, x_ev);
    chk(wr && !x_ev ? "R7" : "R8", "writeback", resp_wb, x_wb);
    if (x_wb) chk("R8", "wb_addr", wb_addr, x_addr);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed = 32'h1d2c3b4a;
    for (int s = 0; s < SETS; s++) m_len[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready", req_ready, 1);
    chk("R11", "resp_valid", resp_valid, 0);
    chk("R11", "counters", {hit_cnt, miss_cnt, evict_cnt, wb_cnt}, 0);

    // R1: offsets share a line, index selects the set
    access(2'd0, 1, 0, 0, 2'd1, "R1");
    access(2'd0, 1, 0, 15, 2'd1, "R1");
    access(2'd1, 1, 1, 7, 2'd1, "R1");
    // R3 then R5: free ways first, LRU victim afterward
    for (int t = 1; t <= 4; t++) access(2'd0, t, 2, 0, 2'd1, "R3");
    access(2'd0, 1, 2, 0, 2'd1, "R5");
    access(2'd0, 5, 2, 0, 2'd1, "R5");
    access(2'd0, 6, 2, 0, 2'd3, "R5");
    // R4: FIFO ignores hits
    for (int t = 1; t <= 4; t++) access(2'd1, t, 3, 0, 2'd0, "R4");
    access(2'd0, 1, 3, 0, 2'd0, "R4");
    access(2'd0, 5, 3, 0, 2'd0, "R4");
    // R6: MRU evicts the newest
    for (int t = 2; t <= 4; t++) access(2'd0, t, 1, 0, 2'd2, "R6");
    access(2'd0, 2, 1, 0, 2'd2, "R6");
    access(2'd0, 5, 1, 0, 2'd2, "R6");
    access(2'd0, 6, 1, 0, 2'd2, "R6");
    // R7/R8/R9: dirty write, invalidate writes back, then miss
    access(2'd1, 1, 0, 3, 2'd1, "R7");
    access(2'd2, 1, 0, 0, 2'd1, "R9");
    access(2'd2, 1, 0, 0, 2'd1, "R9");
    access(2'd0, 1, 0, 0, 2'd1, "R9");

    // sweep: all policies, six tags per set, mixed ops
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] op, pol;
      int r;
      string rq;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 16) & 32'hffff;
      pol = 2'((i / 125) % 4);
      op = (r % 10 < 5) ? 2'd0 : (r % 10 < 8) ? 2'd1 : (r % 10 < 9) ? 2'd2 : 2'd3;
      rq = (pol == 2'd0) ? "R4" : (pol == 2'd2) ? "R6" : "R5";
      access(op, (r / 10) % 6, (r / 60) % SETS, (r / 240) % 16, pol, rq);
    end

    chk("R10", "hit count", hit_cnt, e_hit);
    chk("R10", "miss count", miss_cnt, e_miss);
    chk("R10", "evict count", evict_cnt, e_evict);
    chk("R10", "wb count", wb_cnt, e_wb);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule